// File: doc/BRIEF.md
# Multi-Channel Aligned PWM with Phase Offsets

This block drives four independent pulse-width-modulated outputs from one clock. Each channel has its own 16-bit period, pulse width, alignment mode and phase preset. A single shared start strobe loads every channel at the same time, so the channels keep fixed phase relationships to one another. The intended use is staggering switching edges across several power stages so that their current steps do not coincide.

Each channel runs a down counter that covers the range from the period value to one. The output is high when the count is at or below the pulse width; in left-aligned mode the count is compared in mirrored form. Center alignment counts down and then back up, which gives a symmetric pulse over two periods. New period, width and alignment values are held off until the channel reaches its terminal count, so a running waveform never shows a torn cycle. Each channel also has one interrupt pulse output. Its source is selected per channel: the terminal count, or the low-to-high transition of the output.

Top module: `pwmx_multi`

## Requirements
- R1: From reset until the first start strobe, every PWM output and every interrupt output is low.
- R2: When `sync_i` is high at a clock edge, every channel loads its counter preset, takes its period, width and alignment from the inputs, begins counting down, and starts running. This happens whether or not the channel was already running.
- R3: In right and left alignment the counter steps P, P-1, ..., 1 and then reloads, so one cycle lasts P clocks. A period input of 0 behaves as 1.
- R4: Alignment code 2'b00 (right) drives the output high while the count is at or below the width W, which is the last W clocks of each cycle.
- R5: Alignment code 2'b01 (left) drives the output high while count + W is greater than P, which is the first W clocks of each cycle.
- R6: Alignment codes 2'b10 and 2'b11 (center) count P down to 1, hold 1 for one further clock while turning around, then count up to P. The cycle lasts 2P clocks, and the output is high while the count is at or below W.
- R7: A width of 0 keeps the output low for the whole cycle. A width at or above the effective period keeps it high for the whole cycle.
- R8: A change to the period, width or alignment inputs while a channel runs takes effect only at that channel's terminal count, or at a start strobe. The terminal count is the count of 1 in right/left mode, and the count of P while counting up in center mode.
- R9: With the channel's `irq_sel_i` bit at 0, the interrupt output is high in exactly the clocks where the running channel sits at its terminal count.
- R10: With the `irq_sel_i` bit at 1, the interrupt output is high for one clock in each clock where the PWM output is high and was low in the previous clock.
- R11: The phase preset loaded at a start strobe is the channel's phase input when that value lies between 1 and the effective period. Any other value loads the effective period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Shared start/resynchronise strobe |
| period_i | input | 64 | Per-channel period, 16 bits per channel, channel 0 in the low bits |
| width_i | input | 64 | Per-channel pulse width |
| phase_i | input | 64 | Per-channel counter preset applied at the start strobe |
| align_i | input | 8 | Per-channel alignment code, 2 bits per channel |
| irq_sel_i | input | 4 | Per-channel interrupt source: 0 terminal count, 1 output rising edge |
| pwm_o | output | 4 | PWM outputs |
| irq_o | output | 4 | Single-clock interrupt pulses |

## Verification
The bench aims at the edges of the counter range. These are period 0 and period 1, where a wrong reload produces a stuck or runaway counter. They also include widths of 0 and at or above the period, where an off-by-one compare would leak a one-clock glitch. Phase presets of 0 and of values above the period are tested too; a missing clamp would start the channel outside its cycle and shift every later edge. Configuration is changed in the middle of a cycle, so a design that applied new values at once would show a torn pulse. Resynchronisation in the middle of a run checks that every channel restarts on the same clock. The center-mode turnaround is exercised as well, since a design that skipped the hold at count 1 would produce an odd-length cycle and an off-center pulse.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  typedef enum logic [1:0] {
    ALN_RIGHT = 2'b00,
    ALN_LEFT  = 2'b01,
    ALN_CTR   = 2'b10,
    ALN_CTR_B = 2'b11
  } align_e;

  function automatic logic is_center(input logic [1:0] a);
    return a[1];
  endfunction
endpackage

// File: rtl/pwmx_timebase.sv
module pwmx_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] width_i,
  input  logic [CW-1:0] phase_i,
  input  logic [1:0]    align_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] wid_o,
  output logic [1:0]    aln_o,
  output logic          run_o,
  output logic          tc_o
);
  import pwmx_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] per_q, per_n;
  logic [CW-1:0] wid_q, wid_n;
  logic [1:0]    aln_q, aln_n;
  logic          up_q, up_n;
  logic          run_q, run_n;
  logic          en;
  logic          tc;
  logic [CW-1:0] per_in_eff;
  logic [CW-1:0] preset;

  // Effective period never drops below one clock.
  assign per_in_eff = (period_i == '0) ? ONE : period_i;
  assign preset     = (phase_i != '0 && phase_i <= per_in_eff) ? phase_i : per_in_eff;

  assign tc = run_q && (is_center(aln_q) ? (up_q && cnt_q == per_q) : (cnt_q == ONE));
  assign en = sync_i | run_q;

  always_comb begin
    cnt_n = cnt_q;
    per_n = per_q;
    wid_n = wid_q;
    aln_n = aln_q;
    up_n  = up_q;
    run_n = run_q;
    if (sync_i) begin
      per_n = per_in_eff;
      wid_n = width_i;
      aln_n = align_i;
      cnt_n = preset;
      up_n  = 1'b0;
      run_n = 1'b1;
    end else if (tc) begin
      per_n = per_in_eff;
      wid_n = width_i;
      aln_n = align_i;
      cnt_n = per_in_eff;
      up_n  = 1'b0;
    end else if (is_center(aln_q) && !up_q && cnt_q == ONE) begin
      up_n  = 1'b1;
    end else if (is_center(aln_q) && up_q) begin
      cnt_n = cnt_q + ONE;
    end else begin
      cnt_n = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      wid_q <= '0;
      aln_q <= ALN_RIGHT;
      up_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_n;
      per_q <= per_n;
      wid_q <= wid_n;
      aln_q <= aln_n;
      up_q  <= up_n;
      run_q <= run_n;
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
  assign wid_o = wid_q;
  assign aln_o = aln_q;
  assign run_o = run_q;
  assign tc_o  = tc;
endmodule

// File: rtl/pwmx_outstage.sv
module pwmx_outstage #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] wid_i,
  input  logic [1:0]    aln_i,
  input  logic          run_i,
  input  logic          tc_i,
  input  logic          irq_sel_i,
  output logic          pwm_o,
  output logic          irq_o
);
  import pwmx_pkg::*;

  localparam int SW = CW + 1;

  logic [SW-1:0] mirror_sum;
  logic          hit;
  logic          pwm;
  logic          prev_q, prev_n;

  assign mirror_sum = {1'b0, cnt_i} + {1'b0, wid_i};

  always_comb begin
    if (align_e'(aln_i) == ALN_LEFT) hit = mirror_sum > {1'b0, per_i};
    else                             hit = cnt_i <= wid_i;
  end

  assign pwm    = run_i & hit;
  assign prev_n = pwm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_n;
  end

  assign pwm_o = pwm;
  assign irq_o = run_i & (irq_sel_i ? (pwm & ~prev_q) : tc_i);
endmodule

// File: rtl/pwmx_multi.sv
module pwmx_multi #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [NCH*CW-1:0] period_i,
  input  logic [NCH*CW-1:0] width_i,
  input  logic [NCH*CW-1:0] phase_i,
  input  logic [NCH*2-1:0]  align_i,
  input  logic [NCH-1:0]    irq_sel_i,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    irq_o
);
  localparam int AW = 2;

  logic [NCH*CW-1:0] cnt_flat;
  logic [NCH*CW-1:0] per_flat;
  logic [NCH*CW-1:0] wid_flat;
  logic [NCH*AW-1:0] aln_flat;
  logic [NCH-1:0]    run_vec;
  logic [NCH-1:0]    tc_vec;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmx_timebase #(.CW(CW)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (sync_i),
      .period_i(period_i[g*CW +: CW]),
      .width_i (width_i[g*CW +: CW]),
      .phase_i (phase_i[g*CW +: CW]),
      .align_i (align_i[g*AW +: AW]),
      .cnt_o   (cnt_flat[g*CW +: CW]),
      .per_o   (per_flat[g*CW +: CW]),
      .wid_o   (wid_flat[g*CW +: CW]),
      .aln_o   (aln_flat[g*AW +: AW]),
      .run_o   (run_vec[g]),
      .tc_o    (tc_vec[g])
    );

    pwmx_outstage #(.CW(CW)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_i    (cnt_flat[g*CW +: CW]),
      .per_i    (per_flat[g*CW +: CW]),
      .wid_i    (wid_flat[g*CW +: CW]),
      .aln_i    (aln_flat[g*AW +: AW]),
      .run_i    (run_vec[g]),
      .tc_i     (tc_vec[g]),
      .irq_sel_i(irq_sel_i[g]),
      .pwm_o    (pwm_o[g]),
      .irq_o    (irq_o[g])
    );
  end
endmodule

// File: rtl/pwmx_multi_chk.sv
module pwmx_multi_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_i,
  input logic [NCH-1:0]    irq_sel_i,
  input logic [NCH-1:0]    pwm_o,
  input logic [NCH-1:0]    irq_o,
  input logic [NCH*CW-1:0] cnt_flat,
  input logic [NCH*CW-1:0] per_flat,
  input logic [NCH*CW-1:0] wid_flat,
  input logic [NCH-1:0]    run_vec
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (sync_i) seen_q <= 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (pwm_o == '0 && irq_o == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_cnt_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      run_vec[g] |-> (cnt_flat[g*CW +: CW] >= CW'(1) &&
                      cnt_flat[g*CW +: CW] <= per_flat[g*CW +: CW]));

    assert_period_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_vec[g] |-> per_flat[g*CW +: CW] != '0);

    assert_zero_width_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_vec[g] && wid_flat[g*CW +: CW] == '0) |-> !pwm_o[g]);

    assert_full_width_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_vec[g] && wid_flat[g*CW +: CW] >= per_flat[g*CW +: CW]) |-> pwm_o[g]);

    assert_rise_irq_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sel_i[g] && irq_o[g]) |-> (pwm_o[g] && !$past(pwm_o[g])));
  end
endmodule

bind pwmx_multi pwmx_multi_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sync_i   (sync_i),
  .irq_sel_i(irq_sel_i),
  .pwm_o    (pwm_o),
  .irq_o    (irq_o),
  .cnt_flat (cnt_flat),
  .per_flat (per_flat),
  .wid_flat (wid_flat),
  .run_vec  (run_vec)
);

// File: tb/pwmx_multi_bench.sv
module pwmx_multi_bench;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic              clk;
  logic              rst_n;
  logic              sync_i;
  logic [NCH*CW-1:0] period_i;
  logic [NCH*CW-1:0] width_i;
  logic [NCH*CW-1:0] phase_i;
  logic [NCH*2-1:0]  align_i;
  logic [NCH-1:0]    irq_sel_i;
  logic [NCH-1:0]    pwm_o;
  logic [NCH-1:0]    irq_o;

  pwmx_multi #(.NCH(NCH), .CW(CW)) u_pwmx_multi (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .period_i(period_i), .width_i(width_i), .phase_i(phase_i),
    .align_i(align_i), .irq_sel_i(irq_sel_i),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  string tag = "R1";

  // Behavioural reference state per channel.
  int m_run [NCH];
  int m_cnt [NCH];
  int m_up  [NCH];
  int m_per [NCH];
  int m_wid [NCH];
  int m_aln [NCH];
  int m_prev[NCH];

  function automatic int in_per(int c);
    int p = int'(period_i[c*CW +: CW]);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic int m_pwm(int c);
    if (m_run[c] == 0) return 0;
    if (m_aln[c] == 1) return (m_cnt[c] + m_wid[c] > m_per[c]) ? 1 : 0;
    return (m_cnt[c] <= m_wid[c]) ? 1 : 0;
  endfunction

  function automatic int m_tc(int c);
    if (m_run[c] == 0) return 0;
    if (m_aln[c] >= 2) return (m_up[c] != 0 && m_cnt[c] == m_per[c]) ? 1 : 0;
    return (m_cnt[c] == 1) ? 1 : 0;
  endfunction

  function automatic int m_irq(int c);
    if (m_run[c] == 0) return 0;
    if (irq_sel_i[c]) return (m_pwm(c) == 1 && m_prev[c] == 0) ? 1 : 0;
    return m_tc(c);
  endfunction

  task automatic take_cfg(int c);
    m_per[c] = in_per(c);
    m_wid[c] = int'(width_i[c*CW +: CW]);
    m_aln[c] = int'(align_i[c*2 +: 2]);
    m_up[c]  = 0;
  endtask

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        m_run[c] = 0; m_cnt[c] = 0; m_up[c] = 0; m_per[c] = 0;
        m_wid[c] = 0; m_aln[c] = 0; m_prev[c] = 0;
      end else begin
        int tc_now;
        int ph;
        tc_now = m_tc(c);
        m_prev[c] = m_pwm(c);
        if (sync_i) begin
          take_cfg(c);
          ph = int'(phase_i[c*CW +: CW]);
          m_cnt[c] = (ph >= 1 && ph <= m_per[c]) ? ph : m_per[c];
          m_run[c] = 1;
        end else if (m_run[c] != 0) begin
          if (tc_now != 0) begin
            take_cfg(c);
            m_cnt[c] = m_per[c];
          end else if (m_aln[c] >= 2 && m_up[c] == 0 && m_cnt[c] == 1) begin
            m_up[c] = 1;
          end else if (m_aln[c] >= 2 && m_up[c] != 0) begin
            m_cnt[c] = m_cnt[c] + 1;
          end else begin
            m_cnt[c] = m_cnt[c] - 1;
          end
        end
      end
    end
  end

  task automatic check_all();
    for (int c = 0; c < NCH; c++) begin
      int ep, ei;
      ep = m_pwm(c);
      ei = m_irq(c);
      vectors++;
      if (int'(pwm_o[c]) != ep || int'(irq_o[c]) != ei) begin
        fails++;
        $display("FAIL %s ch%0d t=%0t pwm/irq actual=%0d/%0d expected=%0d/%0d",
                 tag, c, $time, pwm_o[c], irq_o[c], ep, ei);
      end
    end
  endtask

  task automatic cycles(int n);
    repeat (n) begin
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic cfg(int c, int p, int w, int a, int ph, int s);
    period_i[c*CW +: CW] = CW'(p);
    width_i[c*CW +: CW]  = CW'(w);
    align_i[c*2 +: 2]    = 2'(a);
    phase_i[c*CW +: CW]  = CW'(ph);
    irq_sel_i[c]         = s[0];
  endtask

  task automatic strobe();
    sync_i = 1'b1;
    cycles(1);
    sync_i = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_run[c] = 0; m_cnt[c] = 0; m_up[c] = 0; m_per[c] = 0;
      m_wid[c] = 0; m_aln[c] = 0; m_prev[c] = 0;
    end
    rst_n = 1'b0; sync_i = 1'b0;
    period_i = '0; width_i = '0; phase_i = '0; align_i = '0; irq_sel_i = '0;

    // R1: reset and idle before the first strobe.
    tag = "R1";
    cycles(3);
    rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) cfg(c, 6, 3, 0, 2, 0);
    cycles(12);

    // R4: right alignment, staggered phases.
    tag = "R4";
    cfg(0, 8, 3, 0, 8, 0); cfg(1, 8, 3, 0, 6, 1);
    cfg(2, 5, 1, 0, 1, 0); cfg(3, 7, 6, 0, 4, 1);
    strobe(); cycles(40);

    // R5: left alignment.
    tag = "R5";
    cfg(0, 8, 3, 1, 8, 1); cfg(1, 6, 1, 1, 3, 0);
    cfg(2, 5, 4, 1, 2, 1); cfg(3, 9, 5, 1, 9, 0);
    strobe(); cycles(40);

    // R6: center alignment with both codes.
    tag = "R6";
    cfg(0, 5, 2, 2, 5, 0); cfg(1, 4, 1, 3, 2, 1);
    cfg(2, 1, 0, 2, 1, 0); cfg(3, 6, 3, 2, 3, 1);
    strobe(); cycles(50);

    // R7: zero and full width.
    tag = "R7";
    cfg(0, 6, 0, 0, 3, 1); cfg(1, 6, 6, 1, 3, 1);
    cfg(2, 4, 9, 2, 4, 0); cfg(3, 5, 0, 2, 2, 0);
    strobe(); cycles(30);

    // R3: period of zero and one.
    tag = "R3";
    cfg(0, 0, 1, 0, 0, 0); cfg(1, 1, 1, 1, 1, 1);
    cfg(2, 1, 1, 2, 1, 0); cfg(3, 0, 0, 1, 5, 0);
    strobe(); cycles(20);

    // R8: mid-cycle config changes wait for terminal count.
    tag = "R8";
    cfg(0, 10, 4, 0, 10, 0); cfg(1, 10, 4, 1, 7, 0);
    cfg(2, 6, 2, 2, 6, 0); cfg(3, 9, 3, 0, 2, 0);
    strobe(); cycles(3);
    cfg(0, 4, 1, 1, 10, 0); cfg(1, 12, 9, 0, 7, 0);
    cfg(2, 3, 3, 0, 6, 0); cfg(3, 5, 2, 2, 2, 0);
    cycles(4);
    cfg(0, 7, 5, 2, 10, 0);
    cycles(40);

    // R9: terminal-count interrupts.
    tag = "R9";
    cfg(0, 3, 1, 0, 3, 0); cfg(1, 5, 2, 1, 4, 0);
    cfg(2, 3, 1, 2, 3, 0); cfg(3, 2, 1, 0, 1, 0);
    strobe(); cycles(30);

    // R10: rising-edge interrupts, source switched on the fly.
    tag = "R10";
    for (int c = 0; c < NCH; c++) irq_sel_i[c] = 1'b1;
    cycles(25);
    irq_sel_i = 4'b0101;
    cycles(15);

    // R11: out-of-range phase presets.
    tag = "R11";
    cfg(0, 6, 2, 0, 0, 0); cfg(1, 6, 2, 0, 7, 0);
    cfg(2, 6, 2, 0, 65535, 1); cfg(3, 6, 2, 2, 100, 1);
    strobe(); cycles(25);

    // R2: resynchronisation in mid-run.
    tag = "R2";
    cfg(0, 7, 3, 0, 2, 1); cfg(1, 7, 3, 0, 5, 1);
    cfg(2, 7, 3, 1, 7, 0); cfg(3, 7, 3, 2, 1, 0);
    cycles(9);
    strobe(); cycles(11);
    strobe(); strobe(); cycles(20);

    // R3: mixed pseudo-random configurations.
    tag = "R3";
    for (int it = 0; it < 24; it++) begin
      for (int c = 0; c < NCH; c++)
        cfg(c, int'($urandom_range(0, 12)), int'($urandom_range(0, 14)),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 14)),
            int'($urandom_range(0, 1)));
      if (it % 3 == 0) strobe();
      cycles(int'($urandom_range(10, 40)));
    end

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule